// File: doc/BRIEF.md
# Chained Three-Counter Interval Timer

The block holds three 16-bit down-counters driven from one byte-wide register port. Counter 2 counts a master clock-enable pulse and serves as a prescaler. Each of its terminal events steps counters 0 and 1 once, so their periods are the product of the two reload values. Counter 0 is meant as the periodic system tick. Counter 1, loaded with the largest value, is meant as a wrapping timebase. A terminal event on counter 0 or counter 1 sets a sticky interrupt flag. Software acknowledges these flags through a write-one-to-clear register.

Software programs each counter in three steps. A control byte picks the channel, the access type and the operating mode. The reload value then goes in as a low byte followed by a high byte. A counter can be read live at any time. It can also be frozen with a latch command and then read back as a stable pair of bytes. Setting a counter to the strobe mode halts it, which is how channels are kept quiet at start-up.

Top module: `chained_interval_timer`

## Requirements
- R1: Address 3 is the control register. Its bits [7:6] pick the channel (0 to 2; value 3 is ignored), bits [5:4] pick the access (00 latch command, any other value a 16-bit low/high load) and bits [3:0] pick the mode (0100 rate generator, any other value strobe/stopped). A control write that is not a latch command stops the channel and resets its byte toggles.
- R2: Data ports are at addresses 0, 1 and 2 for channels 0, 1 and 2. The first write after a control write stores the low byte and the second write stores the high byte. Only the high-byte write changes the count and starts the channel. Until then the channel keeps counting on its old value.
- R3: A latch command freezes the channel's current count. The next two reads of its data port return the low byte and then the high byte of the frozen value, and the latch is then released.
- R4: Without a pending latch, data-port reads return the live count, low byte first, then high byte, alternating.
- R5: Channel 2 decrements on every cycle in which tick_en_i is high. Channels 0 and 1 decrement once per terminal event of channel 2, so their period is the product of the two reload values in tick_en_i cycles.
- R6: In rate-generator mode, the input event that finds the count at 1 produces a one-event terminal pulse and reloads the stored value. The period therefore equals the reload value, and a reload of 0 means 65536.
- R7: A terminal event of channel 0 sets irq_o[0] and one of channel 1 sets irq_o[1]. The flags stay set until cleared, and a new event in the same cycle as a clear wins over the clear.
- R8: Writing address 4 clears flag 0 when data bit 0 is 1 and flag 1 when data bit 1 is 1. Writing 0x03 clears both flags and zero bits leave the flags unchanged.
- R9: A low/high load whose value is 1 is refused. The channel stays stopped and its count and stored value are unchanged.
- R10: In strobe mode the channel does not count and gives no terminal events, so its downstream channels and flags do not move. A full load in this mode still sets the count.
- R11: A reload of 0xFFFF on channel 1 gives a period of 65535 terminal events of channel 2.
- R12: After reset all counts are 0, all channels are stopped and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Master count enable for channel 2 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Data-port read strobe (advances byte toggle) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed data port (valid in the read cycle) |
| irq_o | output | 2 | Sticky interrupt flags of channels 0 and 1 |

## Verification
The bench measures tick and wrap periods for random prescaler and channel reload values. A design that clocked channels 0 and 1 from the master enable, or that reloaded one event early or late, would show the wrong period. Directed cases cover a low byte written alone, which must not restart the count, and a latch that must hold its value while counting goes on. They also cover a reload of 1, which must be refused, and strobe mode, which must freeze counting. Selective clears show whether the acknowledge register masks the wrong bit. A full 0xFFFF wrap on channel 1 is timed to the exact cycle, which exposes a counter that treats 0xFFFF or 0 as a special case.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned PRE_CH  = 2;
  localparam int unsigned NUM_IRQ = 2;
  localparam logic [2:0]  ADDR_CTRL = 3'd3;
  localparam logic [2:0]  ADDR_CLR  = 3'd4;
  localparam logic [1:0]  ACC_LATCH = 2'b00;
  localparam logic [3:0]  OPM_RATE  = 4'b0100;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [3:0] opm;
  } ctrl_t;
endpackage

// File: rtl/cit_channel.sv
module cit_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_i,
  input  logic       cfg_wr_i,
  input  logic       cfg_rate_i,
  input  logic       latch_i,
  input  logic       dat_wr_i,
  input  logic       dat_rd_i,
  input  logic [7:0] dat_i,
  output logic [7:0] rdata_o,
  output logic       tc_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cnt_q, reload_q, lat_val_q, new_val, view;
  logic [7:0]       lo_q;
  logic             rate_q, run_q, wr_hi_q, rd_hi_q, lat_q;
  logic             load_hi, accept;

  assign new_val = {dat_i[HI_W-1:0], lo_q};
  assign load_hi = dat_wr_i & wr_hi_q;
  // reload of 1 is refused
  assign accept  = load_hi & (new_val != CNT_W'(1));
  assign tc_o    = ev_i & run_q & (cnt_q == CNT_W'(1));
  assign view    = lat_q ? lat_val_q : cnt_q;
  assign rdata_o = rd_hi_q ? 8'(view >> 8) : view[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      reload_q  <= '0;
      lat_val_q <= '0;
      lo_q      <= '0;
      rate_q    <= 1'b0;
      run_q     <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      lat_q     <= 1'b0;
    end else begin
      if (cfg_wr_i) begin
        rate_q  <= cfg_rate_i;
        run_q   <= 1'b0;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
        lat_q   <= 1'b0;
      end else if (dat_wr_i) begin
        wr_hi_q <= ~wr_hi_q;
        if (!wr_hi_q) lo_q <= dat_i;
        if (accept) begin
          reload_q <= new_val;
          run_q    <= rate_q;
        end
      end
      if (accept) cnt_q <= new_val;
      else if (ev_i && run_q) cnt_q <= (cnt_q == CNT_W'(1)) ? reload_q : cnt_q - CNT_W'(1);
      if (latch_i && !lat_q) begin
        lat_val_q <= cnt_q;
        lat_q     <= 1'b1;
        rd_hi_q   <= 1'b0;
      end else if (dat_rd_i) begin
        rd_hi_q <= ~rd_hi_q;
        if (rd_hi_q) lat_q <= 1'b0;
      end
    end
  end

  // R6
  tc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !accept) |=> (cnt_q == $past(reload_q)));
  // R10
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !accept) |=> $stable(cnt_q));
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q |=> $stable(lat_val_q));
  // R9
  no_unit_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (reload_q != CNT_W'(1)));
endmodule

// File: rtl/cit_irq.sv
module cit_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~(clr_wr_i ? clr_i : '0));
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/chained_interval_timer.sv
module chained_interval_timer
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_en_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [2:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  ctrl_t             ctrl;
  logic              ctrl_wr;
  logic [NUM_CH-1:0] tc, ev;
  logic [7:0]        ch_rd [NUM_CH];

  assign ctrl    = ctrl_t'(wdata_i);
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
    localparam logic [1:0] ID = 2'(i);
    if (i == int'(PRE_CH)) begin : g_pre
      assign ev[i] = tick_en_i;
    end else begin : g_sub
      assign ev[i] = tc[PRE_CH];
    end
    cit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (ev[i]),
      .cfg_wr_i   (ctrl_wr && ctrl.sel == ID && ctrl.acc != ACC_LATCH),
      .cfg_rate_i (ctrl.opm == OPM_RATE),
      .latch_i    (ctrl_wr && ctrl.sel == ID && ctrl.acc == ACC_LATCH),
      .dat_wr_i   (wr_en_i && addr_i == 3'(i)),
      .dat_rd_i   (rd_en_i && addr_i == 3'(i)),
      .dat_i      (wdata_i),
      .rdata_o    (ch_rd[i]),
      .tc_o       (tc[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < int'(NUM_CH); k++)
      if (addr_i == 3'(k)) rdata_o = ch_rd[k];
  end

  cit_irq #(.N(NUM_IRQ)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (tc[NUM_IRQ-1:0]),
    .clr_wr_i (wr_en_i && addr_i == ADDR_CLR),
    .clr_i    (wdata_i[NUM_IRQ-1:0]),
    .flag_o   (irq_o)
  );

  // R5
  cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc[NUM_IRQ-1:0]) |-> tc[PRE_CH]);
endmodule

// File: tb/chained_interval_timer_tb_top.sv
module chained_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chained_interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic int exp_period(int pre, int div);
    return pre * div;
  endfunction

  function automatic logic [7:0] ctrl_byte(int ch, bit rate);
    return {2'(ch), 2'b11, rate ? 4'b0100 : 4'b1000};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1ps d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'(ch), lo); rd(3'(ch), hi);
    v = {hi, lo};
  endtask

  task automatic load(int ch, bit rate, logic [15:0] v);
    wr(3'd3, ctrl_byte(ch, rate)); wr(3'(ch), v[7:0]); wr(3'(ch), v[15:8]);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_cnt(int ch, int exp, string req);
    logic [15:0] v;
    rd16(ch, v);
    check(v == 16'(exp), req, v, exp);
  endtask

  task automatic wait_flag(int b, output int at);
    int g = 0;
    while (!irq[b] && g < 5000) begin @(negedge clk); g++; end
    at = cyc;
    if (g >= 5000) check(1'b0, "R5 timeout", 0, 1);
  endtask

  task automatic measure(int b, int exp);
    int a0, a1;
    wr(3'd4, 8'h03);
    wait_flag(b, a0);
    wr(3'd4, 8'(1 << b));
    wait_flag(b, a1);
    check((a1 - a0) == exp, b == 0 ? "R5 R7 period flag0" : "R5 R7 period flag1", a1 - a0, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e, p2, n0, n1;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(irq == 2'b00, "R12 flags", irq, 0);
    expect_cnt(0, 0, "R12 count ch0");
    expect_cnt(2, 0, "R12 count ch2");

    // R1 R2 R4 load and live read
    load(2, 1'b1, 16'h0010);
    expect_cnt(2, 16'h0010, "R1 R2 load");
    ticks(3);
    expect_cnt(2, 16'h000D, "R4 live count");
    wr(3'd2, 8'h20);
    ticks(3);
    expect_cnt(2, 16'h000A, "R2 low byte alone no restart");
    wr(3'd2, 8'h00);
    expect_cnt(2, 16'h0020, "R2 high byte restarts");

    // R3 latch
    wr(3'd3, 8'h80);
    ticks(5);
    expect_cnt(2, 16'h0020, "R3 latched value");
    expect_cnt(2, 16'h001B, "R3 R4 live after latch");

    // R6 reload after reaching 1
    load(2, 1'b1, 16'h0004);
    ticks(3);
    expect_cnt(2, 1, "R6 count at 1");
    ticks(1);
    expect_cnt(2, 4, "R6 reload");
    ticks(2);

    // R9 reload of 1 refused
    load(2, 1'b1, 16'h0001);
    expect_cnt(2, 2, "R9 count kept");
    ticks(3);
    expect_cnt(2, 2, "R9 stays stopped");

    // R10 strobe mode
    load(2, 1'b1, 16'h0100);
    ticks(2);
    expect_cnt(2, 16'h00FE, "R10 running");
    wr(3'd3, ctrl_byte(2, 1'b0));
    ticks(4);
    expect_cnt(2, 16'h00FE, "R10 strobe freezes");
    load(0, 1'b1, 16'h0003);
    ticks(10);
    check(irq == 2'b00, "R10 no downstream events", irq, 0);
    load(2, 1'b0, 16'h0050);
    ticks(3);
    expect_cnt(2, 16'h0050, "R10 load in strobe mode");

    // R1 channel field 3 ignored
    wr(3'd3, 8'hF4);
    wr(3'd3, 8'hC0);
    expect_cnt(2, 16'h0050, "R1 channel 3 ignored");

    // R7 R8 flags and selective clear
    load(0, 1'b1, 16'h0002);
    load(1, 1'b1, 16'h0003);
    load(2, 1'b1, 16'h0002);
    ticks(12);
    check(irq == 2'b11, "R7 both flags set", irq, 3);
    ticks(4);
    check(irq == 2'b11, "R7 flags sticky", irq, 3);
    wr(3'd4, 8'h01);
    check(irq == 2'b10, "R8 clear bit0", irq, 2);
    wr(3'd4, 8'h00);
    check(irq == 2'b10, "R8 zero write no effect", irq, 2);
    wr(3'd4, 8'h02);
    check(irq == 2'b00, "R8 clear bit1", irq, 0);
    ticks(12);
    wr(3'd4, 8'h03);
    check(irq == 2'b00, "R8 clear both", irq, 0);

    // R5 random cascaded periods
    for (int it = 0; it < 6; it++) begin
      p2 = 2 + int'($urandom % 4);
      n0 = 2 + int'($urandom % 5);
      n1 = 2 + int'($urandom % 5);
      load(2, 1'b1, 16'(p2));
      load(0, 1'b1, 16'(n0));
      load(1, 1'b1, 16'(n1));
      @(negedge clk); tick_en = 1'b1;
      measure(0, exp_period(p2, n0));
      measure(1, exp_period(p2, n1));
      tick_en = 1'b0;
    end

    // R11 full wrap on channel 1
    load(0, 1'b0, 16'h0010);
    load(2, 1'b1, 16'h0002);
    wr(3'd4, 8'h03);
    load(1, 1'b1, 16'hFFFF);
    e = cyc;
    expect_cnt(1, 16'hFFFF, "R11 loaded");
    tick_en = 1'b1;
    e = e + 4;
    while (cyc < e + exp_period(2, 65535) - 1) @(negedge clk);
    check(irq[1] == 1'b0, "R11 no early wrap", irq[1], 0);
    @(negedge clk);
    check(irq[1] == 1'b1, "R11 wrap at 65535", irq[1], 1);
    tick_en = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule